// File: doc/BRIEF.md
# Clock-Chip Indexed Register Port with Interrupt Status

This block is the host-facing side of a real-time clock. The host reaches a 128-byte space of registers and battery-style RAM through two byte ports: the even port holds a pointer, and the odd port reads or writes the byte the pointer selects. Four locations are special. The divider/rate control byte sits at 0x0A. The mode/enable byte sits at 0x0B. The interrupt status byte sits at 0x0C. The always-valid byte sits at 0x0D. All other locations are plain storage, which the calendar logic elsewhere also uses.

The block gathers single-cycle flag pulses from the periodic, alarm and update sources into the status byte and drives one interrupt line from them. It also keeps the sub-second position of the time base, which it counts from an input tick at the 32.768 kHz rate. From that count it produces the update-in-progress indication and a strobe for each once-per-second update. The block does not do the calendar arithmetic or generate the periodic rate.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even port (port_sel = 0) loads the pointer with wr_data bits 6:0, and bit 7 is discarded. A read of the even port returns 0xFF.
- R2: An odd-port access (port_sel = 1) to any location other than 0x0A..0x0D writes or reads back that byte of storage. Read data is registered and is valid the cycle after the read strobe.
- R3: After reset, 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00 and 0x0D reads 0x80, and irq is low.
- R4: Writes to 0x0C and 0x0D have no effect. 0x0D always reads 0x80.
- R5: The status byte holds the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. A pulse on pf_set, af_set or uf_set sets the matching bit. Bits 3:0 read 0.
- R6: Reading 0x0C returns its contents, then clears all flags and lowers irq.
- R7: Bit 7 of the status byte is set exactly when a flag is set together with its enable. The enables sit in byte 0x0B at the same bit positions (6 periodic, 5 alarm, 4 update). irq equals that bit.
- R8: A write to 0x0B that enables a flag which is already pending raises irq on the next cycle. A write that leaves no pending flag enabled lowers irq.
- R9: Writing 0x0B with bit 7 (SET) at 1 stores bit 4 as 0. While SET is 1, the update-in-progress bit reads 0 and no update strobe occurs.
- R10: Bit 7 of 0x0A is the update-in-progress bit. It is read-only, and writes to it are ignored.
- R11: With the divider running (0x0A bits 6:4 at or below 010), the update-in-progress bit reads 1 during the last UIP_TICKS ticks of every second. sec_update pulses for one cycle after the tick that ends the second.
- R12: While 0x0A bits 6:5 are 11, the divider is held: no update occurs and the update-in-progress bit reads 0. When 0x0A is rewritten to a running code, the first update follows TICKS_PER_SEC/2 ticks later.
- R13: A flag pulse that arrives in the same cycle as a read of 0x0C is kept. The read returns the value from before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_32k | input | 1 | One-cycle enable at the time-base rate |
| port_sel | input | 1 | 0 selects the pointer port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| pf_set | input | 1 | Periodic flag pulse |
| af_set | input | 1 | Alarm flag pulse |
| uf_set | input | 1 | Update flag pulse |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, high while the status bit 7 is set |
| sec_update | output | 1 | One-cycle strobe for each once-per-second update |

## Verification
The interrupt path is swept over all eight enable combinations for each of the three flag sources. This separates an enable routed to the wrong flag from a flag routed to the wrong status bit. The update-in-progress bit is read before every tick across two full seconds of a small time base, so the window's exact first and last ticks and the strobe's position are each pinned down. Storage is filled with an address-derived pattern over the whole space except the four special bytes, which exposes pointer truncation and aliasing. Further targeted sequences cover divider hold and release, SET, the ignored writes, and a flag arriving during a status read.

// File: rtl/rtc_idx_pkg.sv
`timescale 1ns/1ps
package rtc_idx_pkg;
   localparam int unsigned IDX_CTRL_A = 10;
   localparam int unsigned IDX_MODE_B = 11;
   localparam int unsigned IDX_STAT_C = 12;
   localparam int unsigned IDX_VALID_D = 13;

   localparam int unsigned B_SET = 7;
   localparam int unsigned B_PIE = 6;
   localparam int unsigned B_AIE = 5;
   localparam int unsigned B_UIE = 4;

   localparam logic [6:0] A_RESET = 7'h26;
   localparam logic [7:0] B_RESET = 8'h02;
   localparam logic [7:0] D_VALUE = 8'h80;

   typedef struct packed {
      logic pf;
      logic af;
      logic uf;
   } rtc_flags_t;
endpackage

// File: rtl/rtc_uip_timer.sv
`timescale 1ns/1ps
module rtc_uip_timer #(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned UIP_TICKS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [2:0] div_code_i,
   input  logic       div_wr_i,
   input  logic [2:0] div_new_i,
   input  logic       set_i,
   output logic       uip_o,
   output logic       upd_o
);
   localparam int unsigned CW = $clog2(TICKS_PER_SEC);
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
   localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
   localparam logic [CW-1:0] WIN_START = CW'(TICKS_PER_SEC - UIP_TICKS);

   if (TICKS_PER_SEC < 4) begin : g_bad_tps
      $error("TICKS_PER_SEC must be at least 4");
   end
   if (UIP_TICKS < 1 || UIP_TICKS >= TICKS_PER_SEC / 2) begin : g_bad_uip
      $error("UIP_TICKS must lie between 1 and TICKS_PER_SEC/2");
   end

   logic [CW-1:0] cnt_q;
   logic          held, running, release_now;

   assign held        = (div_code_i[2:1] == 2'b11);
   assign running     = (div_code_i <= 3'd2);
   assign release_now = div_wr_i && held && (div_new_i <= 3'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         upd_o <= 1'b0;
      end else begin
         upd_o <= 1'b0;
         if (release_now) begin
            cnt_q <= HALF;
         end else if (held) begin
            cnt_q <= '0;
         end else if (tick_i && running) begin
            if (cnt_q == LAST) begin
               cnt_q <= '0;
               upd_o <= !set_i;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign uip_o = running && !set_i && (cnt_q >= WIN_START);

   // R11: every update strobe follows a cycle in which the window was open
   a_r11_update_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> $past(uip_o));
   // R12: a held divider never produces an update
   a_r12_held_no_update: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> !upd_o);
endmodule

// File: rtl/rtc_irq_status.sv
`timescale 1ns/1ps
module rtc_irq_status
   import rtc_idx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rtc_flags_t set_i,
   input  logic       clr_i,
   input  rtc_flags_t en_i,
   output rtc_flags_t flags_o,
   output logic       irqf_o
);
   rtc_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (clr_i ? rtc_flags_t'('0) : flags_q) | set_i;
   end

   assign flags_o = flags_q;
   assign irqf_o  = |(flags_q & en_i);

   // R6: a status read with no coincident pulse leaves no flag behind
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (flags_q == '0));
   // R13: a pulse coinciding with a clearing read is kept
   a_r13_pulse_survives: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i.pf) |=> flags_q.pf);
endmodule

// File: rtl/rtc_index_port.sv
`timescale 1ns/1ps
module rtc_index_port
   import rtc_idx_pkg::*;
#(
   parameter int unsigned INDEX_W = 7,
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned UIP_TICKS = 8,
   parameter bit CLEAR_RAM = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_32k,
   input  logic       port_sel,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wr_data,
   input  logic       pf_set,
   input  logic       af_set,
   input  logic       uf_set,
   output logic [7:0] rd_data,
   output logic       irq,
   output logic       sec_update
);
   localparam int unsigned NUM_BYTES = 1 << INDEX_W;
   localparam logic [INDEX_W-1:0] I_A = INDEX_W'(IDX_CTRL_A);
   localparam logic [INDEX_W-1:0] I_B = INDEX_W'(IDX_MODE_B);
   localparam logic [INDEX_W-1:0] I_C = INDEX_W'(IDX_STAT_C);
   localparam logic [INDEX_W-1:0] I_D = INDEX_W'(IDX_VALID_D);

   if (INDEX_W < 4 || INDEX_W > 7) begin : g_bad_index
      $error("INDEX_W must lie between 4 and 7");
   end

   logic [INDEX_W-1:0] idx_q;
   logic [6:0]         a_q;
   logic [7:0]         b_q;
   logic [7:0]         mem [NUM_BYTES];
   logic               odd_wr, wr_a, wr_b, rd_c, is_special, ram_wr;
   logic               uip, irqf;
   rtc_flags_t         flags, pulses, enables;

   assign odd_wr     = wr_en && port_sel;
   assign is_special = (idx_q == I_A) || (idx_q == I_B) || (idx_q == I_C) || (idx_q == I_D);
   assign wr_a       = odd_wr && (idx_q == I_A);
   assign wr_b       = odd_wr && (idx_q == I_B);
   assign ram_wr     = odd_wr && !is_special;
   assign rd_c       = rd_en && port_sel && (idx_q == I_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         a_q   <= A_RESET;
         b_q   <= B_RESET;
      end else begin
         if (wr_en && !port_sel) idx_q <= wr_data[INDEX_W-1:0];
         if (wr_a) a_q <= wr_data[6:0];
         if (wr_b) b_q <= wr_data[B_SET] ? (wr_data & ~(8'h1 << B_UIE)) : wr_data;
      end
   end

   if (CLEAR_RAM) begin : g_ram_cleared
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) mem[i] <= 8'h00;
         end else if (ram_wr) begin
            mem[idx_q] <= wr_data;
         end
      end
   end else begin : g_ram_plain
      always_ff @(posedge clk) begin
         if (ram_wr) mem[idx_q] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= 8'h00;
      end else if (rd_en) begin
         if (!port_sel)          rd_data <= 8'hFF;
         else if (idx_q == I_A)  rd_data <= {uip, a_q};
         else if (idx_q == I_B)  rd_data <= b_q;
         else if (idx_q == I_C)  rd_data <= {irqf, flags.pf, flags.af, flags.uf, 4'b0000};
         else if (idx_q == I_D)  rd_data <= D_VALUE;
         else                    rd_data <= mem[idx_q];
      end
   end

   assign pulses  = '{pf: pf_set, af: af_set, uf: uf_set};
   assign enables = '{pf: b_q[B_PIE], af: b_q[B_AIE], uf: b_q[B_UIE]};

   rtc_irq_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (pulses),
      .clr_i   (rd_c),
      .en_i    (enables),
      .flags_o (flags),
      .irqf_o  (irqf)
   );

   rtc_uip_timer #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .UIP_TICKS     (UIP_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_32k),
      .div_code_i (a_q[6:4]),
      .div_wr_i   (wr_a),
      .div_new_i  (wr_data[6:4]),
      .set_i      (b_q[B_SET]),
      .uip_o      (uip),
      .upd_o      (sec_update)
   );

   assign irq = irqf;

   // R9: SET written with the update enable still stores it as zero
   a_r9_set_drops_uie: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && wr_data[B_SET]) |=> !b_q[B_UIE]);
   // R9: the window stays closed while SET holds the registers
   a_r9_set_hides_uip: assert property (@(posedge clk) disable iff (!rst_n)
      b_q[B_SET] |-> !uip);
   // R7: an enabled periodic pulse raises the line
   a_r7_enabled_pulse_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_set && b_q[B_PIE] && !wr_b) |=> irq);
   // R8: enabling an already pending flag raises the line at once
   a_r8_pending_enable_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && !rd_c && |({wr_data[B_PIE], wr_data[B_AIE], wr_data[B_UIE] & ~wr_data[B_SET]} & flags))
      |=> irq);
   // R4: the valid byte never changes what it returns
   a_r4_valid_constant: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_sel && idx_q == I_D) |=> (rd_data == D_VALUE));
endmodule

// File: tb/test_rtc_index_port.sv
`timescale 1ns/1ps
module test_rtc_index_port;
   localparam int TPS  = 64;
   localparam int UIPT = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0, port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       pf_set = 1'b0, af_set = 1'b0, uf_set = 1'b0;
   logic [7:0] rd_data;
   logic       irq, sec_update;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rtc_index_port #(
      .INDEX_W(7), .TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT), .CLEAR_RAM(1'b1)
   ) i_rtc_index_port (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .port_sel(port_sel),
      .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .pf_set(pf_set),
      .af_set(af_set), .uf_set(uf_set), .rd_data(rd_data), .irq(irq),
      .sec_update(sec_update)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      {tick_32k, port_sel, wr_en, rd_en, pf_set, af_set, uf_set} = '0;
      wr_data = 8'h00;
   endtask

   task automatic set_ptr(input logic [7:0] v);
      port_sel = 1'b0; wr_en = 1'b1; wr_data = v; cyc();
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
      set_ptr(idx);
      port_sel = 1'b1; wr_en = 1'b1; wr_data = v; cyc();
   endtask

   task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
      set_ptr(idx);
      port_sel = 1'b1; rd_en = 1'b1; cyc();
      v = rd_data;
   endtask

   task automatic pulse(input int k);
      pf_set = (k == 0); af_set = (k == 1); uf_set = (k == 2); cyc();
   endtask

   task automatic tick();
      tick_32k = 1'b1; cyc();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int ticks;
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      check("R3 irq", {7'b0, irq}, 8'h00);
      check("R3 sec_update", {7'b0, sec_update}, 8'h00);
      rd_reg(8'd10, v); check("R3 A", v, 8'h26);
      rd_reg(8'd11, v); check("R3 B", v, 8'h02);
      rd_reg(8'd12, v); check("R3 C", v, 8'h00);
      rd_reg(8'd13, v); check("R3 D", v, 8'h80);

      // R11: window sweep over two seconds
      for (int n = 0; n < 2 * TPS; n++) begin
         rd_reg(8'd10, v);
         check("R11 uip", v, ((n % TPS) >= TPS - UIPT) ? 8'hA6 : 8'h26);
         tick();
         check("R11 strobe", {7'b0, sec_update}, ((n % TPS) == TPS - 1) ? 8'h01 : 8'h00);
      end

      // R12: divider hold, then release
      wr_reg(8'd10, 8'h66);
      for (int n = 0; n < TPS + 4; n++) begin
         tick();
         check("R12 held strobe", {7'b0, sec_update}, 8'h00);
      end
      rd_reg(8'd10, v); check("R12 held uip", v, 8'h66);
      wr_reg(8'd10, 8'h26);
      ticks = 0; seen = 0;
      for (int n = 0; n < TPS; n++) begin
         if (seen == 0) begin
            tick(); ticks++;
            if (sec_update) seen = ticks;
         end
      end
      check("R12 half second", 8'(seen), 8'(TPS / 2));

      // R10: bit 7 of A ignores writes (counter now at 0)
      wr_reg(8'd10, 8'hA6);
      rd_reg(8'd10, v); check("R10 set ignored", v, 8'h26);
      for (int n = 0; n < TPS - UIPT; n++) tick();
      wr_reg(8'd10, 8'h26);
      rd_reg(8'd10, v); check("R10 clear ignored", v, 8'hA6);

      // R9: SET drops UIE and hides the window
      wr_reg(8'd11, 8'h92);
      rd_reg(8'd11, v); check("R9 uie forced", v, 8'h82);
      rd_reg(8'd10, v); check("R9 uip hidden", v, 8'h26);
      for (int n = 0; n < UIPT; n++) begin
         tick();
         check("R9 no strobe", {7'b0, sec_update}, 8'h00);
      end
      wr_reg(8'd11, 8'h02);

      // R1: pointer bit 7 dropped, even read
      set_ptr(8'h8A);
      port_sel = 1'b1; rd_en = 1'b1; cyc();
      check("R1 pointer", rd_data & 8'h7F, 8'h26);
      port_sel = 1'b0; rd_en = 1'b1; cyc();
      check("R1 even read", rd_data, 8'hFF);

      // R2: storage sweep
      for (int a = 0; a < 128; a++)
         if (a < 10 || a > 13) wr_reg(8'(a), 8'(a * 7 + 3));
      for (int a = 0; a < 128; a++)
         if (a < 10 || a > 13) begin
            rd_reg(8'(a), v); check("R2 storage", v, 8'(a * 7 + 3));
         end

      // R4: status and valid bytes unwritable
      wr_reg(8'd12, 8'hFF);
      rd_reg(8'd12, v); check("R4 C write", v, 8'h00);
      check("R4 irq", {7'b0, irq}, 8'h00);
      wr_reg(8'd13, 8'h00);
      rd_reg(8'd13, v); check("R4 D write", v, 8'h80);

      // R5 R6 R7: every enable pattern against every flag
      for (int e = 0; e < 8; e++)
         for (int k = 0; k < 3; k++) begin
            logic [7:0] bval, fbit;
            bval = 8'((e << 4) | 2);
            fbit = 8'h40 >> k;
            wr_reg(8'd11, bval);
            pulse(k);
            check("R7 irq", {7'b0, irq}, ((bval & fbit) != 0) ? 8'h01 : 8'h00);
            rd_reg(8'd12, v);
            check("R5 R7 status", v, fbit | (((bval & fbit) != 0) ? 8'h80 : 8'h00));
            check("R6 irq low", {7'b0, irq}, 8'h00);
            rd_reg(8'd12, v); check("R6 cleared", v, 8'h00);
         end

      // R8: enabling a pending flag
      wr_reg(8'd11, 8'h02);
      pulse(1);
      check("R8 pending no enable", {7'b0, irq}, 8'h00);
      wr_reg(8'd11, 8'h22);
      check("R8 raise at once", {7'b0, irq}, 8'h01);
      wr_reg(8'd11, 8'h42);
      check("R8 lowered", {7'b0, irq}, 8'h00);
      rd_reg(8'd12, v); check("R8 status", v, 8'h20);

      // R13: pulse during a status read
      set_ptr(8'd12);
      port_sel = 1'b1; rd_en = 1'b1; pf_set = 1'b1; cyc();
      check("R13 old value", rd_data, 8'h00);
      check("R13 irq kept", {7'b0, irq}, 8'h01);
      rd_reg(8'd12, v); check("R13 flag kept", v, 8'hC0);
      check("R13 irq cleared", {7'b0, irq}, 8'h00);

      finish_run();
   end
endmodule